// File: doc/BRIEF.md
# Synchronised Audio Transport Controller

This block governs when a playback device and a capture device start, stop and advance their sample positions. Several such blocks can sit on a shared synchronisation line, so that many devices start together. Each device has a level-sensitive enable, a local run request, a counter clear and two mode bits (master, slave). Enable alone only arms a device. The device actually runs when its start condition also holds, and the mode bits decide what that condition is.

While a device runs, its 12-bit sample-position counter moves forward by one on each pulse of that device's sample strobe. The counter wraps over a 4096-word buffer. A packed position view returns the top ten bits of both counters, so one step of the view equals four samples. The start line from the shared bus is asynchronous and passes through a two-flop synchroniser. The start line driven onto the bus comes straight from the master and run bits.

Device index 0 is playback and index 1 is capture, on every per-device vector.

Top module: `xport_ctrl`

## Requirements
- R1: `dev_running[d]` is high exactly when `dev_enable[d]` is high and the device's start condition is true. The start condition depends on the mode bits {master,slave}: 00 uses the run bit, 01 uses the synchronised bus start, 10 is never true, and 11 uses the run bit OR the synchronised bus start.
- R2: An enabled device whose start condition is false stays in standby. It does not run, and sample strobes leave its counter unchanged.
- R3: Clearing `dev_enable[d]` drops `dev_running[d]` in the same cycle, whatever run or the bus start is doing. Strobes after that point do not move the counter.
- R4: In slave-only mode (01), the run bit has no effect. The device starts only after `bus_start_i` has been high across two rising clock edges.
- R5: `bus_start_o` is high in the same cycle that any device has both master and run high, whether or not that device is enabled. A master-only device (10) does not start itself.
- R6: A device in mode 11 with enable and run high starts in the same cycle that it raises `bus_start_o`.
- R7: In autonomous mode (00), the bus start has no effect. Enable and run alone decide whether the device runs.
- R8: A running device's counter increments by one on each clock edge where its sample strobe is high. It wraps from 4095 to 0.
- R9: `pos_view[9:0]` holds playback counter bits 11..2 and `pos_view[19:10]` holds capture counter bits 11..2.
- R10: While `dev_cnt_clr[d]` is high, that device's counter is forced to zero and held there, even when the device is running and strobed.
- R11: After reset, both counters are zero, and `dev_running`, `bus_start_o` and `pos_view` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| dev_enable | input | 2 | Per-device enable (arms the device) |
| dev_run | input | 2 | Per-device local run request |
| dev_cnt_clr | input | 2 | Per-device counter clear, level |
| dev_master | input | 2 | Per-device master mode bit |
| dev_slave | input | 2 | Per-device slave mode bit |
| sample_tick | input | 2 | Per-device one-cycle sample strobe |
| bus_start_i | input | 1 | Start line sampled from the shared bus (asynchronous) |
| bus_start_o | output | 1 | Start line driven onto the shared bus |
| dev_running | output | 2 | Per-device running state |
| pos_view | output | 20 | Coarse position view of both counters |

## Verification
The assertions take the control bits to be register outputs that are stable across each clock edge. They take `sample_tick` to be synchronous to `clk`; only `bus_start_i` may change freely. The stimulus changes every input just after a falling edge and holds it for at least one full cycle. It holds the bus start level for two rising edges before it expects any slave device to respond. This keeps the bench within those assumptions and makes the synchroniser latency deterministic.

// File: rtl/xport_pkg.sv
package xport_pkg;
  localparam int NDEV     = 2;
  localparam int DEV_PLAY = 0;
  localparam int DEV_CAP  = 1;

  // Mode encoding as {master, slave}
  typedef enum logic [1:0] {
    MODE_AUTO   = 2'b00,
    MODE_SLAVE  = 2'b01,
    MODE_MASTER = 2'b10,
    MODE_BOTH   = 2'b11
  } xport_mode_e;
endpackage

// File: rtl/xport_bus_sync.sv
module xport_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/xport_dev_gate.sv
module xport_dev_gate
  import xport_pkg::*;
(
  input  logic enable_i,
  input  logic run_i,
  input  logic master_i,
  input  logic slave_i,
  input  logic bus_start_sync_i,
  output logic running_o,
  output logic drive_bus_o
);
  xport_mode_e mode;
  logic        start_cond;

  always_comb begin
    mode = xport_mode_e'({master_i, slave_i});
    unique case (mode)
      MODE_AUTO:   start_cond = run_i;
      MODE_SLAVE:  start_cond = bus_start_sync_i;
      MODE_MASTER: start_cond = 1'b0;
      MODE_BOTH:   start_cond = run_i | bus_start_sync_i;
      default:     start_cond = 1'b0;
    endcase
  end

  assign running_o   = enable_i & start_cond;
  assign drive_bus_o = master_i & run_i;
endmodule

// File: rtl/xport_pos_counter.sv
module xport_pos_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             running_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | (running_i & tick_i);
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R10: clear forces zero on the next edge
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  // R8: one step per strobe while running, modulo 2^CNT_W
  a_r8_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && running_i && tick_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R2: no strobe-while-running and no clear means hold
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !(running_i && tick_i)) |=> $stable(cnt_q));
endmodule

// File: rtl/xport_ctrl.sv
module xport_ctrl
  import xport_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int DROP_BITS   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int VIEW_W     = CNT_W - DROP_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NDEV-1:0]       dev_enable,
  input  logic [NDEV-1:0]       dev_run,
  input  logic [NDEV-1:0]       dev_cnt_clr,
  input  logic [NDEV-1:0]       dev_master,
  input  logic [NDEV-1:0]       dev_slave,
  input  logic [NDEV-1:0]       sample_tick,
  input  logic                  bus_start_i,
  output logic                  bus_start_o,
  output logic [NDEV-1:0]       dev_running,
  output logic [NDEV*VIEW_W-1:0] pos_view
);
  logic                bus_sync;
  logic [NDEV-1:0]     drive_bus;
  logic [CNT_W-1:0]    cnt [NDEV];

  xport_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (bus_start_i),
    .sync_o  (bus_sync)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    xport_dev_gate u_gate (
      .enable_i         (dev_enable[d]),
      .run_i            (dev_run[d]),
      .master_i         (dev_master[d]),
      .slave_i          (dev_slave[d]),
      .bus_start_sync_i (bus_sync),
      .running_o        (dev_running[d]),
      .drive_bus_o      (drive_bus[d])
    );

    xport_pos_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (dev_cnt_clr[d]),
      .running_i (dev_running[d]),
      .tick_i    (sample_tick[d]),
      .cnt_o     (cnt[d])
    );

    assign pos_view[d*VIEW_W +: VIEW_W] = cnt[d][CNT_W-1:DROP_BITS];

    // R3: disabled device never runs
    a_r3_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_enable[d] |-> !dev_running[d]);
    // R4: slave-only device waits for the synchronised bus start
    a_r4_slave_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_slave[d] && !dev_master[d] && !bus_sync) |-> !dev_running[d]);
    // R5: master with run drives the bus line
    a_r5_master_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_master[d] && dev_run[d]) |-> bus_start_o);
  end

  assign bus_start_o = |drive_bus;
endmodule

// File: tb/xport_ctrl_tb_top.sv
module xport_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] en, run, clr, mst, slv, tick;
  logic       bus_in;
  logic       bus_out;
  logic [1:0] running;
  logic [19:0] view;

  int checks = 0;
  int errors = 0;
  int cnt_m [2];
  bit bus_seen;
  bit done = 0;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } exp_item_t;
  exp_item_t exp_q [$];

  always #4 clk = ~clk;

  xport_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .dev_enable(en), .dev_run(run),
    .dev_cnt_clr(clr), .dev_master(mst), .dev_slave(slv),
    .sample_tick(tick), .bus_start_i(bus_in), .bus_start_o(bus_out),
    .dev_running(running), .pos_view(view)
  );

  function automatic bit exp_run(int d);
    case ({mst[d], slv[d]})
      2'b00:   return en[d] & run[d];
      2'b01:   return en[d] & bus_seen;
      2'b10:   return 1'b0;
      default: return en[d] & (run[d] | bus_seen);
    endcase
  endfunction

  function automatic logic [19:0] exp_view();
    logic [11:0] p, c;
    p = 12'(cnt_m[0]);
    c = 12'(cnt_m[1]);
    return {c[11:2], p[11:2]};
  endfunction

  task automatic push_exp(string req, int sel, logic [31:0] e);
    exp_item_t it;
    it.req = req; it.sel = sel; it.exp = e;
    exp_q.push_back(it);
  endtask

  // Push expected running, view and bus line after inputs settle
  task automatic expect_all(string req);
    #1;
    push_exp(req, 0, {30'b0, exp_run(1), exp_run(0)});
    push_exp(req, 1, {12'b0, exp_view()});
    push_exp(req, 2, {31'b0, |(mst & run)});
  endtask

  task automatic do_ticks(int n, logic [1:0] mask);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = mask;
      for (int d = 0; d < 2; d++) begin
        if (clr[d]) cnt_m[d] = 0;
        else if (mask[d] && exp_run(d)) cnt_m[d] = (cnt_m[d] + 1) % 4096;
      end
      @(posedge clk);
    end
    @(negedge clk);
    tick = 2'b00;
  endtask

  // Monitor: pop and compare
  initial begin
    forever begin
      exp_item_t it;
      logic [31:0] act;
      wait (exp_q.size() > 0);
      it = exp_q.pop_front();
      case (it.sel)
        0:       act = {30'b0, running};
        1:       act = {12'b0, view};
        default: act = {31'b0, bus_out};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  // Watchdog
  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en = '0; run = '0; clr = '0; mst = '0; slv = '0; tick = '0; bus_in = 1'b0;
    cnt_m[0] = 0; cnt_m[1] = 0; bus_seen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_all("R11 reset state");
    rst_n = 1'b1;

    // R2: enabled but no run -> standby, ticks ignored
    @(negedge clk); en = 2'b01;
    do_ticks(5, 2'b01);
    expect_all("R2 standby holds");

    // R1/R7: autonomous run counts; R8/R9 view layout
    @(negedge clk); run = 2'b01;
    expect_all("R1 enable and run start play");
    do_ticks(8, 2'b01);
    expect_all("R8 R9 play count 8 view 2");

    // R7: capture autonomous ignores bus start
    @(negedge clk); en = 2'b11; bus_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); bus_seen = 1;
    expect_all("R7 autonomous capture ignores bus");
    do_ticks(4, 2'b10);
    expect_all("R7 capture stays at zero");

    // R3: drop play enable while run held
    @(negedge clk); en = 2'b10;
    expect_all("R3 disable stops same cycle");
    do_ticks(6, 2'b01);
    expect_all("R3 no counting after disable");

    // R10: clear while running and ticking holds zero
    @(negedge clk); en = 2'b01; clr = 2'b01;
    do_ticks(4, 2'b01);
    cnt_m[0] = 0;
    expect_all("R10 clear holds zero");
    @(negedge clk); clr = 2'b00;
    do_ticks(4, 2'b01);
    expect_all("R10 count resumes after clear");

    // R4: capture slave-only, run ignored
    @(negedge clk); bus_in = 1'b0; en = 2'b10; run = 2'b10; slv = 2'b10;
    repeat (2) @(posedge clk);
    @(negedge clk); bus_seen = 0;
    expect_all("R4 slave ignores run");
    bus_in = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_all("R4 one edge still idle");
    @(posedge clk); @(negedge clk); bus_seen = 1;
    expect_all("R4 slave starts after two edges");
    do_ticks(12, 2'b10);
    expect_all("R4 R9 capture count 12 view 3");

    // R5: master-only play drives bus but does not start itself
    @(negedge clk); bus_in = 1'b0; slv = 2'b00; run = 2'b00; en = 2'b01;
    repeat (2) @(posedge clk);
    @(negedge clk); bus_seen = 0;
    mst = 2'b01; run = 2'b01;
    expect_all("R5 master drives bus, not self");
    en = 2'b00;
    expect_all("R5 drives bus without enable");

    // R6: master+slave starts in same cycle as bus drive
    @(negedge clk); en = 2'b00; run = 2'b00; mst = 2'b01; slv = 2'b01;
    expect_all("R6 idle before run");
    @(negedge clk); en = 2'b01; run = 2'b01;
    expect_all("R6 both mode starts with bus drive");

    // R8: wrap from 4095 to 0
    @(negedge clk); clr = 2'b01;
    @(posedge clk); @(negedge clk); clr = 2'b00; cnt_m[0] = 0;
    do_ticks(4095, 2'b01);
    expect_all("R8 play at 4095 view 1023");
    do_ticks(1, 2'b01);
    expect_all("R8 play wraps to 0");

    #2;
    wait (exp_q.size() == 0);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule